// File: doc/BRIEF.md
# SMBus Address Resolution Responder

This block is the address-resolution layer of an SMBus slave. A separate bit engine handles SCL/SDA timing and hands it byte-level events: start (including repeated start), stop, received bytes with a flag marking the address byte, a request for the next byte to transmit, and a loss-of-arbitration indication. The block tells the engine whether to ACK each received byte. It supplies transmit bytes on request. It decodes the general and directed address-resolution commands and holds the resulting slave address together with its valid and resolved flags.

A 128-bit unique device identifier is assembled from fixed fields, parameters, a 3-bit location strap and a 16-bit per-device random value. The straps and the random value are latched once after reset. A mode strap selects between ARP-capable operation and fixed-address operation. In ARP-capable operation the master may assign the address. In fixed-address operation the address comes from the strap. Every command carries a packet error code, which is a CRC-8 over all bytes of the transaction including the address bytes. The block checks that code on commands it receives and generates it on the identifier it sends back.

Top module: `arp_responder`

## Requirements
- R1: An address byte of 0xC2 (default address 0x61, write) received after a start is acknowledged. Any other address byte that does not continue a pending Get UDID is answered with NACK. Each ACK/NACK decision appears on rsp_valid/rsp_ack in the cycle after rx_valid.
- R2: The packet error code is CRC-8 with polynomial 0x07 and initial value 0, taken MSB first over every byte of the transaction including the address bytes. A write command whose final byte differs from this CRC is NACKed on that byte and changes neither the address nor the flags.
- R3: The location strap and random value are latched once after reset. Later changes on those inputs do not alter the identifier until the next reset.
- R4: Get UDID is the sequence 0xC2, command, repeated start, 0xC3. On successive transmit requests it returns 0x11, then the 16 identifier bytes most significant first, then {address,1}, then the CRC of all bytes of the transaction. Each byte is valid on tx_valid/tx_data in the cycle after tx_req.
- R5: The identifier bytes, most significant first, are: 0xC1, 0x0A, VENDOR_ID (2 bytes), DEVICE_ID (2 bytes), 0x00, 0x04, four 0x00 bytes, 0x00, {5'b0, location}, random[15:8], random[7:0].
- R6: Reset in ARP-capable mode leaves the address at 0x7F with valid and resolved clear. Assign Address (command 0x04, count 0x11, 16 identifier bytes, byte {new,x}, code) with a matching identifier and a good code sets the address to the new value and sets both flags.
- R7: During Assign Address, the first identifier byte that differs from the device's own identifier is NACKed, and all later bytes of that transaction are NACKed. The address and flags stay unchanged.
- R8: Prepare to ARP (0x01) with a good code clears the resolved flag. While the resolved flag is set, the general Get UDID command byte 0x03 is NACKed. When the flag is clear, that byte is ACKed.
- R9: When the address is valid, the command byte {address,0} starts a directed Get UDID and {address,1} starts a directed Reset Device. Reset Device, general (0x02) or directed, clears the resolved flag. In ARP-capable mode it also clears the valid flag and returns the address to 0x7F.
- R10: In fixed-address mode the address is FIXED_BASE OR location, and the valid flag is set. Assign Address leaves the address unchanged, and directed Get UDID works at the fixed address.
- R11: A command byte that matches none of the codes above is NACKed.
- R12: A loss-of-arbitration indication during Get UDID ends transmission. tx_valid stays low for all transmit requests that follow in that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_strap | input | 3 | Location strap, latched after reset |
| mode_arp_strap | input | 1 | 1 selects ARP-capable mode, 0 selects fixed-address mode; latched after reset |
| rnd_strap | input | 16 | Per-device random value, latched after reset |
| bus_start | input | 1 | Start or repeated start seen |
| bus_stop | input | 1 | Stop seen |
| rx_valid | input | 1 | A byte was received |
| rx_addr | input | 1 | The received byte is the address byte |
| rx_data | input | 8 | Received byte |
| rsp_valid | output | 1 | ACK decision valid |
| rsp_ack | output | 1 | 1 acknowledges, 0 not-acknowledges |
| tx_req | input | 1 | Engine requests the next byte to send |
| arb_lost | input | 1 | Engine lost arbitration on the byte being sent |
| tx_valid | output | 1 | tx_data holds a byte to send |
| tx_data | output | 8 | Byte to send |
| dev_addr | output | 7 | Current slave address |
| addr_valid | output | 1 | Address-valid flag |
| addr_resolved | output | 1 | Address-resolved flag |

## Verification
The bench sweeps every location value in both modes and checks each transmitted identifier byte and the trailing CRC against a bitwise CRC computed in the bench. A design that latched the strap continuously, ordered a field wrongly or left an address byte out of the CRC would fail these checks. Assign Address is run with a corrupted identifier byte, which must draw a NACK at exactly that index and leave the address alone. It is also run in fixed mode, where a design that forgot the mode gate would move the address. Bad-code commands, unknown commands, general Get UDID while resolved, directed Reset and arbitration loss are each checked at the ACK, flag and transmit outputs.

// File: rtl/arp_pkg.sv
package arp_pkg;
   localparam int ADDR_W      = 7;
   localparam int UDID_BYTES  = 16;
   localparam int UDID_BITS   = UDID_BYTES * 8;
   localparam logic [6:0] ADDR_NONE = 7'h7F;

   localparam logic [7:0] OP_PREP   = 8'h01;
   localparam logic [7:0] OP_RST_G  = 8'h02;
   localparam logic [7:0] OP_GET_G  = 8'h03;
   localparam logic [7:0] OP_ASSIGN = 8'h04;
   localparam logic [7:0] UDID_LEN  = 8'h11;

   localparam logic [7:0]  F_CAPS    = 8'hC1;
   localparam logic [7:0]  F_VERREV  = 8'h0A;
   localparam logic [15:0] F_IFACE   = 16'h0004;
   localparam logic [15:0] F_SUBVEND = 16'h0000;
   localparam logic [15:0] F_SUBDEV  = 16'h0000;

   typedef enum logic [2:0] {
      ST_IDLE, ST_CMD, ST_DATA, ST_PEC, ST_WAITRD, ST_TX, ST_DROP
   } arp_state_t;

   typedef enum logic [1:0] {
      K_PREP, K_RST, K_GET, K_ASSIGN
   } arp_kind_t;

   function automatic logic [7:0] crc8_step(input logic [7:0] c,
                                            input logic [7:0] d,
                                            input logic [7:0] poly);
      logic [7:0] r;
      r = c ^ d;
      for (int i = 0; i < 8; i++)
         r = r[7] ? ((r << 1) ^ poly) : (r << 1);
      return r;
   endfunction
endpackage

// File: rtl/arp_crc8.sv
module arp_crc8 #(
   parameter logic [7:0] POLY = 8'h07
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       upd,
   input  logic [7:0] din,
   output logic [7:0] crc
);
   import arp_pkg::*;

   generate
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("CRC polynomial must have its constant term set");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= 8'h00;
      else if (clr) crc <= 8'h00;
      else if (upd) crc <= crc8_step(crc, din, POLY);
   end
endmodule

// File: rtl/arp_udid.sv
module arp_udid #(
   parameter logic [15:0] VENDOR_ID = 16'h1AB5,
   parameter logic [15:0] DEVICE_ID = 16'h0D27,
   parameter int          LOC_W     = 3,
   parameter int          RND_W     = 16
) (
   input  logic [LOC_W-1:0] loc,
   input  logic [RND_W-1:0] rnd,
   input  logic [3:0]       sel,
   output logic [7:0]       byte_o
);
   import arp_pkg::*;
   localparam int PAD_W = 32 - LOC_W - RND_W;

   generate
      if (PAD_W < 0) begin : g_bad_vsid
         $error("location and random fields exceed the 32-bit vendor field");
      end
   endgenerate

   logic [31:0]          vsid;
   logic [UDID_BITS-1:0] udid;
   logic [7:0]           bytes_a [UDID_BYTES];

   assign vsid = {{PAD_W{1'b0}}, loc, rnd};
   assign udid = {F_CAPS, F_VERREV, VENDOR_ID, DEVICE_ID, F_IFACE,
                  F_SUBVEND, F_SUBDEV, vsid};

   for (genvar g = 0; g < UDID_BYTES; g++) begin : g_slice
      assign bytes_a[g] = udid[UDID_BITS-1-8*g -: 8];
   end

   assign byte_o = bytes_a[sel];
endmodule

// File: rtl/arp_addr_state.sv
module arp_addr_state #(
   parameter logic [6:0] FIXED_BASE = 7'h50,
   parameter int         LOC_W      = 3,
   parameter int         RND_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LOC_W-1:0] loc_strap,
   input  logic             mode_strap,
   input  logic [RND_W-1:0] rnd_strap,
   input  logic             do_prep,
   input  logic             do_reset,
   input  logic             do_assign,
   input  logic [6:0]       new_addr,
   output logic [LOC_W-1:0] loc_q,
   output logic [RND_W-1:0] rnd_q,
   output logic             cap_done,
   output logic [6:0]       dev_addr,
   output logic             addr_valid,
   output logic             addr_resolved
);
   import arp_pkg::*;

   generate
      if ((FIXED_BASE & 7'((1 << LOC_W) - 1)) != 7'd0) begin : g_bad_base
         $error("FIXED_BASE must leave the location bits clear");
      end
   endgenerate

   logic       arp_q;
   logic [6:0] asg_addr;
   logic       asg_valid;
   logic [6:0] fixed_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_done <= 1'b0;
         arp_q    <= 1'b1;
         loc_q    <= '0;
         rnd_q    <= '0;
      end else if (!cap_done) begin
         cap_done <= 1'b1;
         arp_q    <= mode_strap;
         loc_q    <= loc_strap;
         rnd_q    <= rnd_strap;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asg_addr      <= ADDR_NONE;
         asg_valid     <= 1'b0;
         addr_resolved <= 1'b0;
      end else if (do_assign && arp_q) begin
         asg_addr      <= new_addr;
         asg_valid     <= 1'b1;
         addr_resolved <= 1'b1;
      end else if (do_reset) begin
         addr_resolved <= 1'b0;
         if (arp_q) begin
            asg_valid <= 1'b0;
            asg_addr  <= ADDR_NONE;
         end
      end else if (do_prep) begin
         addr_resolved <= 1'b0;
      end
   end

   assign fixed_addr = FIXED_BASE | 7'(loc_q);
   assign dev_addr   = (!cap_done || arp_q) ? asg_addr : fixed_addr;
   assign addr_valid = arp_q ? asg_valid : cap_done;

   assert_loc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_done && $past(cap_done)) |-> ($stable(loc_q) && $stable(rnd_q)));

   assert_resolved_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      addr_resolved |-> addr_valid);

   assert_fixed_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_done && $past(cap_done) && !arp_q) |-> $stable(dev_addr));
endmodule

// File: rtl/arp_responder.sv
module arp_responder #(
   parameter logic [15:0] VENDOR_ID  = 16'h1AB5,
   parameter logic [15:0] DEVICE_ID  = 16'h0D27,
   parameter logic [6:0]  ARP_ADDR   = 7'h61,
   parameter logic [6:0]  FIXED_BASE = 7'h50,
   parameter logic [7:0]  CRC_POLY   = 8'h07,
   parameter int          LOC_W      = 3,
   parameter int          RND_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LOC_W-1:0] loc_strap,
   input  logic             mode_arp_strap,
   input  logic [RND_W-1:0] rnd_strap,
   input  logic             bus_start,
   input  logic             bus_stop,
   input  logic             rx_valid,
   input  logic             rx_addr,
   input  logic [7:0]       rx_data,
   output logic             rsp_valid,
   output logic             rsp_ack,
   input  logic             tx_req,
   input  logic             arb_lost,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   output logic [6:0]       dev_addr,
   output logic             addr_valid,
   output logic             addr_resolved
);
   import arp_pkg::*;
   localparam logic [4:0] LAST_UDID = 5'(UDID_BYTES);
   localparam logic [4:0] IDX_ADDR  = 5'(UDID_BYTES + 1);
   localparam logic [4:0] IDX_PEC   = 5'(UDID_BYTES + 2);

   generate
      if (ARP_ADDR == FIXED_BASE) begin : g_bad_addr
         $error("ARP default address must differ from the fixed base");
      end
   endgenerate

   arp_state_t       state, state_n;
   arp_kind_t        kind, kind_n;
   logic [4:0]       cnt, cnt_n;
   logic [6:0]       naddr, naddr_n;
   logic             rsp_v_n, rsp_a_n, tx_v_n;
   logic [7:0]       tx_d_n;
   logic             crc_clr, crc_upd;
   logic [7:0]       crc_din, crc;
   logic             do_prep, do_reset, do_assign;
   logic [LOC_W-1:0] loc_q;
   logic [RND_W-1:0] rnd_q;
   logic             cap_done;
   logic [3:0]       udid_sel;
   logic [7:0]       udid_byte;
   logic [7:0]       tx_byte;

   arp_crc8 #(.POLY(CRC_POLY)) crc_i (
      .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
      .din(crc_din), .crc(crc)
   );

   arp_udid #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
              .LOC_W(LOC_W), .RND_W(RND_W)) udid_i (
      .loc(loc_q), .rnd(rnd_q), .sel(udid_sel), .byte_o(udid_byte)
   );

   arp_addr_state #(.FIXED_BASE(FIXED_BASE), .LOC_W(LOC_W),
                    .RND_W(RND_W)) addr_i (
      .clk(clk), .rst_n(rst_n), .loc_strap(loc_strap),
      .mode_strap(mode_arp_strap), .rnd_strap(rnd_strap),
      .do_prep(do_prep), .do_reset(do_reset), .do_assign(do_assign),
      .new_addr(naddr), .loc_q(loc_q), .rnd_q(rnd_q), .cap_done(cap_done),
      .dev_addr(dev_addr), .addr_valid(addr_valid),
      .addr_resolved(addr_resolved)
   );

   assign udid_sel = cnt[3:0] - 4'd1;

   always_comb begin
      if (cnt == 5'd0)          tx_byte = UDID_LEN;
      else if (cnt <= LAST_UDID) tx_byte = udid_byte;
      else if (cnt == IDX_ADDR)  tx_byte = {dev_addr, 1'b1};
      else                       tx_byte = crc;
   end

   always_comb begin
      state_n   = state;
      kind_n    = kind;
      cnt_n     = cnt;
      naddr_n   = naddr;
      rsp_v_n   = 1'b0;
      rsp_a_n   = 1'b0;
      tx_v_n    = 1'b0;
      tx_d_n    = tx_data;
      crc_clr   = 1'b0;
      crc_upd   = 1'b0;
      crc_din   = rx_data;
      do_prep   = 1'b0;
      do_reset  = 1'b0;
      do_assign = 1'b0;
      if (bus_stop) begin
         state_n = ST_IDLE;
         crc_clr = 1'b1;
      end else if (bus_start) begin
         if (state != ST_WAITRD) begin
            state_n = ST_IDLE;
            crc_clr = 1'b1;
         end
      end else if (rx_valid) begin
         rsp_v_n = 1'b1;
         state_n = ST_DROP;
         if (rx_addr) begin
            if (state == ST_IDLE && rx_data == {ARP_ADDR, 1'b0}) begin
               rsp_a_n = 1'b1;
               state_n = ST_CMD;
            end else if (state == ST_WAITRD && rx_data == {ARP_ADDR, 1'b1}) begin
               rsp_a_n = 1'b1;
               state_n = ST_TX;
               cnt_n   = 5'd0;
            end
         end else begin
            case (state)
               ST_CMD: begin
                  rsp_a_n = 1'b1;
                  if (rx_data == OP_PREP) begin
                     kind_n = K_PREP;   state_n = ST_PEC;
                  end else if (rx_data == OP_RST_G) begin
                     kind_n = K_RST;    state_n = ST_PEC;
                  end else if (rx_data == OP_GET_G && !addr_resolved) begin
                     kind_n = K_GET;    state_n = ST_WAITRD;
                  end else if (rx_data == OP_ASSIGN) begin
                     kind_n = K_ASSIGN; state_n = ST_DATA; cnt_n = 5'd0;
                  end else if (addr_valid && rx_data == {dev_addr, 1'b1}) begin
                     kind_n = K_RST;    state_n = ST_PEC;
                  end else if (addr_valid && rx_data == {dev_addr, 1'b0}) begin
                     kind_n = K_GET;    state_n = ST_WAITRD;
                  end else begin
                     rsp_a_n = 1'b0;
                  end
               end
               ST_DATA: begin
                  state_n = ST_DATA;
                  cnt_n   = cnt + 5'd1;
                  if (cnt == 5'd0) begin
                     rsp_a_n = (rx_data == UDID_LEN);
                  end else if (cnt <= LAST_UDID) begin
                     rsp_a_n = (rx_data == udid_byte);
                  end else begin
                     rsp_a_n = 1'b1;
                     naddr_n = rx_data[7:1];
                     state_n = ST_PEC;
                  end
                  if (!rsp_a_n) state_n = ST_DROP;
               end
               ST_PEC: begin
                  if (rx_data == crc) begin
                     rsp_a_n   = 1'b1;
                     do_prep   = (kind == K_PREP);
                     do_reset  = (kind == K_RST);
                     do_assign = (kind == K_ASSIGN);
                  end
               end
               default: ;
            endcase
         end
         crc_upd = rsp_a_n;
      end else if (state == ST_TX) begin
         if (arb_lost) begin
            state_n = ST_DROP;
         end else if (tx_req) begin
            tx_v_n  = 1'b1;
            tx_d_n  = tx_byte;
            crc_din = tx_byte;
            crc_upd = (cnt != IDX_PEC);
            cnt_n   = cnt + 5'd1;
            if (cnt == IDX_PEC) state_n = ST_DROP;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind      <= K_PREP;
         cnt       <= 5'd0;
         naddr     <= ADDR_NONE;
         rsp_valid <= 1'b0;
         rsp_ack   <= 1'b0;
         tx_valid  <= 1'b0;
         tx_data   <= 8'h00;
      end else begin
         state     <= state_n;
         kind      <= kind_n;
         cnt       <= cnt_n;
         naddr     <= naddr_n;
         rsp_valid <= rsp_v_n;
         rsp_ack   <= rsp_a_n;
         tx_valid  <= tx_v_n;
         tx_data   <= tx_d_n;
      end
   end

   assert_rsp_follows_rx_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(rx_valid));

   assert_tx_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(tx_req));

   assert_no_tx_after_arb_R12: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |=> !tx_valid);

   assert_capture_before_traffic_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ack |-> cap_done);
endmodule

// File: tb/arp_responder_tb_top.sv
`timescale 1ns/1ps
module arp_responder_tb_top;
   localparam logic [15:0] VID = 16'h1AB5;
   localparam logic [15:0] DID = 16'h0D27;
   localparam logic [6:0]  FBASE = 7'h50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  loc_strap = 3'd0;
   logic        mode_arp_strap = 1'b1;
   logic [15:0] rnd_strap = 16'h0;
   logic        bus_start = 0, bus_stop = 0, rx_valid = 0, rx_addr = 0;
   logic [7:0]  rx_data = 8'h0;
   logic        tx_req = 0, arb_lost = 0;
   logic        rsp_valid, rsp_ack, tx_valid;
   logic [7:0]  tx_data;
   logic [6:0]  dev_addr;
   logic        addr_valid, addr_resolved;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] crc;

   always #2.5 clk = ~clk;

   arp_responder dut_i (
      .clk(clk), .rst_n(rst_n), .loc_strap(loc_strap),
      .mode_arp_strap(mode_arp_strap), .rnd_strap(rnd_strap),
      .bus_start(bus_start), .bus_stop(bus_stop), .rx_valid(rx_valid),
      .rx_addr(rx_addr), .rx_data(rx_data), .rsp_valid(rsp_valid),
      .rsp_ack(rsp_ack), .tx_req(tx_req), .arb_lost(arb_lost),
      .tx_valid(tx_valid), .tx_data(tx_data), .dev_addr(dev_addr),
      .addr_valid(addr_valid), .addr_resolved(addr_resolved)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] crc_add(input logic [7:0] c, input logic [7:0] d);
      logic fb;
      for (int i = 7; i >= 0; i--) begin
         fb = c[7] ^ d[i];
         c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
      return c;
   endfunction

   function automatic logic [7:0] exp_udid(input logic [2:0] loc,
                                           input logic [15:0] rnd, input int i);
      case (i)
         0: return 8'hC1;   1: return 8'h0A;
         2: return VID[15:8]; 3: return VID[7:0];
         4: return DID[15:8]; 5: return DID[7:0];
         7: return 8'h04;
         13: return {5'b0, loc};
         14: return rnd[15:8]; 15: return rnd[7:0];
         default: return 8'h00;
      endcase
   endfunction

   task automatic do_reset(input bit arp, input logic [2:0] loc, input logic [15:0] rnd);
      @(negedge clk);
      rst_n = 0; mode_arp_strap = arp; loc_strap = loc; rnd_strap = rnd;
      repeat (2) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);
   endtask

   task automatic start_c;
      @(negedge clk) bus_start = 1;
      @(negedge clk) bus_start = 0;
   endtask

   task automatic stop_c;
      @(negedge clk) bus_stop = 1;
      @(negedge clk) bus_stop = 0;
      crc = 8'h00;
   endtask

   task automatic send(input logic [7:0] b, input bit is_addr, output bit ack);
      @(negedge clk);
      rx_valid = 1; rx_addr = is_addr; rx_data = b;
      @(negedge clk);
      rx_valid = 0; rx_addr = 0;
      ack = rsp_valid & rsp_ack;
      if (ack) crc = crc_add(crc, b);
   endtask

   task automatic recv(output logic [7:0] b, output bit v);
      @(negedge clk) tx_req = 1;
      @(negedge clk) tx_req = 0;
      v = tx_valid; b = tx_data;
   endtask

   // full Get UDID with byte-by-byte comparison
   task automatic get_full(input logic [7:0] code, input logic [2:0] loc,
                           input logic [15:0] rnd, input logic [6:0] ea,
                           input string tag);
      bit a; bit v; logic [7:0] b; logic [7:0] e;
      crc = 8'h00;
      start_c();
      send(8'hC2, 1, a); chk(a, {tag, " addr C2 ack"}, a, 1);
      send(code, 0, a);  chk(a, {tag, " cmd ack"}, a, 1);
      start_c();
      send(8'hC3, 1, a); chk(a, {tag, " addr C3 ack"}, a, 1);
      for (int i = 0; i < 19; i++) begin
         if (i == 0) e = 8'h11;
         else if (i <= 16) e = exp_udid(loc, rnd, i - 1);
         else if (i == 17) e = {ea, 1'b1};
         else e = crc;
         recv(b, v);
         chk(v && b == e, $sformatf("%s byte %0d", tag, i), {v, b}, {1'b1, e});
         if (i < 18) crc = crc_add(crc, e);
      end
      stop_c();
   endtask

   task automatic assign_seq(input logic [2:0] loc, input logic [15:0] rnd,
                             input logic [6:0] na, input int bad, output int first_nack);
      bit a; logic [7:0] b;
      first_nack = -1;
      crc = 8'h00;
      start_c();
      send(8'hC2, 1, a);
      send(8'h04, 0, a); if (!a && first_nack < 0) first_nack = 100;
      send(8'h11, 0, a); if (!a && first_nack < 0) first_nack = 101;
      for (int i = 0; i < 16; i++) begin
         b = exp_udid(loc, rnd, i);
         if (i == bad) b = b ^ 8'h40;
         send(b, 0, a);
         if (!a && first_nack < 0) first_nack = i;
      end
      send({na, 1'b0}, 0, a); if (!a && first_nack < 0) first_nack = 116;
      send(crc, 0, a);        if (!a && first_nack < 0) first_nack = 117;
      stop_c();
   endtask

   task automatic simple_cmd(input logic [7:0] code, input bit good_pec,
                             output bit a_cmd, output bit a_pec);
      bit a;
      crc = 8'h00;
      start_c();
      send(8'hC2, 1, a);
      send(code, 0, a_cmd);
      send(good_pec ? crc : ~crc, 0, a_pec);
      stop_c();
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      bit a, a2, v; int fn; logic [7:0] b;
      crc = 8'h00;
      do_reset(1, 3'd5, 16'hBEEF);
      chk(dev_addr == 7'h7F && !addr_valid && !addr_resolved, "R6 reset state",
          {dev_addr, addr_valid, addr_resolved}, {7'h7F, 2'b00});

      loc_strap = 3'd2; rnd_strap = 16'h1234;   // R3: late change ignored
      get_full(8'h03, 3'd5, 16'hBEEF, 7'h7F, "R3 R4 R5 general get");

      crc = 8'h00; start_c();
      send(8'hA0, 1, a); chk(!a, "R1 foreign address nack", a, 0);
      stop_c();

      simple_cmd(8'h09, 1, a, a2); chk(!a, "R11 unknown cmd nack", a, 0);

      simple_cmd(8'h01, 0, a, a2);
      chk(a && !a2, "R2 bad PEC nack", {a, a2}, 2'b10);
      simple_cmd(8'h01, 1, a, a2);
      chk(a && a2, "R2 good PEC ack", {a, a2}, 2'b11);

      assign_seq(3'd5, 16'hBEEF, 7'h2A, 7, fn);
      chk(fn == 7, "R7 mismatch nack index", fn, 7);
      chk(dev_addr == 7'h7F && !addr_valid, "R7 address kept", dev_addr, 7'h7F);

      assign_seq(3'd5, 16'hBEEF, 7'h2A, -1, fn);
      chk(fn == -1, "R6 assign all ack", fn, 32'hFFFFFFFF);
      chk(dev_addr == 7'h2A && addr_valid && addr_resolved, "R6 assigned",
          {dev_addr, addr_valid, addr_resolved}, {7'h2A, 2'b11});

      simple_cmd(8'h03, 1, a, a2); chk(!a, "R8 general get nack when resolved", a, 0);

      get_full(8'h54, 3'd5, 16'hBEEF, 7'h2A, "R9 directed get");

      simple_cmd(8'h01, 1, a, a2);
      chk(!addr_resolved && addr_valid, "R8 prepare clears resolved",
          {addr_valid, addr_resolved}, 2'b10);
      crc = 8'h00; start_c();
      send(8'hC2, 1, a); send(8'h03, 0, a);
      chk(a, "R8 general get ack after prepare", a, 1);
      stop_c();

      assign_seq(3'd5, 16'hBEEF, 7'h2A, -1, fn);
      simple_cmd(8'h55, 1, a, a2);
      chk(a && a2, "R9 directed reset ack", {a, a2}, 2'b11);
      chk(!addr_valid && !addr_resolved && dev_addr == 7'h7F, "R9 reset clears",
          {dev_addr, addr_valid, addr_resolved}, {7'h7F, 2'b00});
      simple_cmd(8'h54, 1, a, a2); chk(!a, "R9 directed get nack when invalid", a, 0);

      // R12 arbitration loss
      crc = 8'h00; start_c();
      send(8'hC2, 1, a); send(8'h03, 0, a); start_c(); send(8'hC3, 1, a);
      for (int i = 0; i < 3; i++) recv(b, v);
      @(negedge clk) arb_lost = 1;
      @(negedge clk) arb_lost = 0;
      recv(b, v); chk(!v, "R12 silent after arb loss", v, 0);
      recv(b, v); chk(!v, "R12 still silent", v, 0);
      stop_c();

      for (int l = 0; l < 8; l++) begin
         do_reset(1, 3'(l), 16'h5A00 + 16'(l * 37));
         get_full(8'h03, 3'(l), 16'h5A00 + 16'(l * 37), 7'h7F, $sformatf("R5 sweep loc %0d", l));
      end

      for (int l = 0; l < 8; l++) begin
         do_reset(0, 3'(l), 16'hC3A5 ^ 16'(l));
         chk(dev_addr == (FBASE | 7'(l)) && addr_valid, "R10 fixed address",
             {dev_addr, addr_valid}, {FBASE | 7'(l), 1'b1});
         assign_seq(3'(l), 16'hC3A5 ^ 16'(l), 7'h2A, -1, fn);
         chk(dev_addr == (FBASE | 7'(l)), "R10 assign ignored", dev_addr, FBASE | 7'(l));
         get_full({FBASE | 7'(l), 1'b0}, 3'(l), 16'hC3A5 ^ 16'(l), FBASE | 7'(l),
                  "R10 fixed directed get");
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule